// File: doc/BRIEF.md
# Infix to Postfix Token Converter

This block takes a stream of arithmetic tokens written in ordinary infix order and re-emits them in postfix (reverse Polish) order, ready for a stack-based evaluator. Operands pass straight through. Operators and open parentheses wait on an internal operator stack until the ordering rules release them. Every incoming token is compared with the entry on top of that stack. One of six actions follows: push, pop one operator to the output, delete a matching parenthesis pair, pass an operand through, finish, or fail. A single input token can take several cycles, one pop per cycle, before it is consumed.

An expression opens with a start token and closes with an end token. Both sides of the block use valid/ready handshakes. The input is held off while operators drain, and output backpressure is honoured through a one-entry output register. The block signals `done` when an expression is complete and `error` when the stream is malformed. Both flags stay set until the next start token begins a fresh expression.

Control is a four-state machine:
- IDLE: the stack is empty after reset. A start token goes to RUN; any other token goes to FAIL.
- RUN: tokens are processed. The end token meeting the start marker goes to DONE. An illegal pairing or a push onto a full stack goes to FAIL.
- DONE and FAIL: further tokens are consumed and ignored. A start token clears the stack, pushes the marker and goes back to RUN.

Top module: `infix_postfix_cvt`

## Requirements
- R1: After reset, `out_valid`, `done` and `error` are low and `in_ready` is high.
- R2: The start token (kind 7) must be the first token after reset. Any other first token raises `error`. A start token accepted while `done` or `error` is set clears both flags and begins a new expression.
- R3: Operand tokens (kind 0) are never stacked. They appear at the output with their 8-bit value unchanged and in their input order.
- R4: Multiply (3) and divide (4) bind more tightly than add (1) and subtract (2). Operators of equal rank group left to right. Every emitted operator carries value 0.
- R5: Open (5) and close (6) parentheses group sub-expressions. A close meeting an open on the stack deletes both, and no parenthesis ever reaches the output.
- R6: The end token (kind 8) releases all remaining operators and then raises `done`. `done` holds until a start token is accepted.
- R7: A close parenthesis with no open partner, or an end token while an open parenthesis is pending, raises `error`.
- R8: The stack holds 16 entries, the start marker included. A push onto a full stack raises `error`; filling the stack exactly does not.
- R9: While `out_valid` is high and `out_ready` is low, the output token stays unchanged and no token is lost.
- R10: An input token that must first pop an operator sees `in_ready` low during that pop.
- R11: A kind code of 9 to 15, or a start token in the middle of an expression, raises `error`.
- R12: `done` and `error` are never high together. After `error` is raised, later non-start tokens produce no output and leave `error` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input token valid |
| in_ready | output | 1 | Input token accepted this cycle when valid |
| in_kind | input | 4 | Input token kind code |
| in_val | input | 8 | Operand value (ignored for other kinds) |
| out_valid | output | 1 | Output token valid |
| out_ready | input | 1 | Downstream accepts the output token |
| out_kind | output | 4 | Output token kind (0 to 4 only) |
| out_val | output | 8 | Output operand value, 0 for operators |
| done | output | 1 | Expression converted successfully |
| error | output | 1 | Malformed stream detected |

## Verification
A corrupted stack entry or a wrong stack pointer shows up as a reordered or missing operator at the output. The bench sees this by the time the end token has drained, at the latest, because it compares the whole postfix stream of each expression against a precedence-based reference. A wrong state shows up within one token: a stray `done` or `error`, an expression that is still accepted after a failure, or `in_ready` staying high during a pop. Random expressions mix nesting, mixed precedence and single corrupted tokens under random output backpressure, so most stack paths are stressed every run.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    localparam int KIND_W = 4;
    localparam int VAL_W  = 8;

    typedef logic [KIND_W-1:0] kind_t;
    typedef logic [VAL_W-1:0]  val_t;

    // Token kind codes seen at both ports
    localparam kind_t K_OPND  = 4'd0;
    localparam kind_t K_ADD   = 4'd1;
    localparam kind_t K_SUB   = 4'd2;
    localparam kind_t K_MUL   = 4'd3;
    localparam kind_t K_DIV   = 4'd4;
    localparam kind_t K_LPAR  = 4'd5;
    localparam kind_t K_RPAR  = 4'd6;
    localparam kind_t K_START = 4'd7;
    localparam kind_t K_END   = 4'd8;

    typedef enum logic [2:0] {
        ACT_PUSH,
        ACT_POP,
        ACT_DROP,
        ACT_EMIT,
        ACT_DONE,
        ACT_FAIL
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE,
        ST_FAIL
    } state_e;

    function automatic logic is_arith(kind_t k);
        return (k == K_ADD) || (k == K_SUB) || (k == K_MUL) || (k == K_DIV);
    endfunction

    function automatic logic is_tight(kind_t k);
        return (k == K_MUL) || (k == K_DIV);
    endfunction

endpackage

// File: rtl/cvt_rule.sv
module cvt_rule
    import cvt_pkg::*;
(
    input  kind_t top_kind,
    input  kind_t in_kind,
    output act_e  act
);

    always_comb begin : p_rule
        act = ACT_FAIL;
        unique case (in_kind)
            K_OPND: act = ACT_EMIT;
            K_ADD, K_SUB: begin
                // loose operators release every stacked operator
                act = is_arith(top_kind) ? ACT_POP : ACT_PUSH;
            end
            K_MUL, K_DIV: begin
                // tight operators release only tight operators
                act = is_tight(top_kind) ? ACT_POP : ACT_PUSH;
            end
            K_LPAR: act = ACT_PUSH;
            K_RPAR: begin
                if (top_kind == K_LPAR)       act = ACT_DROP;
                else if (top_kind == K_START) act = ACT_FAIL;
                else                          act = ACT_POP;
            end
            K_END: begin
                if (top_kind == K_START)      act = ACT_DONE;
                else if (top_kind == K_LPAR)  act = ACT_FAIL;
                else                          act = ACT_POP;
            end
            default: act = ACT_FAIL;
        endcase
    end

endmodule

// File: rtl/cvt_stack.sv
module cvt_stack
    import cvt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  push,
    input  logic  pop,
    input  kind_t din,
    output kind_t top,
    output logic  full
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0]                cnt_q;
    logic [CW-1:0]                wr_ptr;
    logic [IW-1:0]                top_idx;
    logic [DEPTH-1:0][KIND_W-1:0] slots;

    assign wr_ptr  = clr ? '0 : cnt_q;
    assign top_idx = IW'(cnt_q - CW'(1));
    assign top     = slots[top_idx];
    assign full    = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin : p_cnt
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= push ? CW'(1) : '0;
        end else if (push) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (pop) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        kind_t entry_q;
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == CW'(i))) begin
                entry_q <= din;
            end
        end
        assign slots[i] = entry_q;
    end

endmodule

// File: rtl/cvt_outbuf.sv
module cvt_outbuf
    import cvt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  kind_t ld_kind,
    input  val_t  ld_val,
    output logic  free,
    input  logic  out_ready,
    output logic  out_valid,
    output kind_t out_kind,
    output val_t  out_val
);

    assign free = !out_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin : p_hold
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= K_OPND;
            out_val   <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_kind  <= ld_kind;
            out_val   <= ld_val;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/infix_postfix_cvt.sv
module infix_postfix_cvt
    import cvt_pkg::*;
#(
    parameter int STACK_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [KIND_W-1:0]   in_kind,
    input  logic [VAL_W-1:0]    in_val,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [KIND_W-1:0]   out_kind,
    output logic [VAL_W-1:0]    out_val,
    output logic                done,
    output logic                error
);

    state_e state_q, state_d;
    act_e   act;

    logic  stk_clr, stk_push, stk_pop, stk_full;
    kind_t stk_din, stk_top;
    logic  ob_load, ob_free;
    kind_t ob_kind;
    val_t  ob_val;

    cvt_rule u_rule (
        .top_kind (stk_top),
        .in_kind  (in_kind),
        .act      (act)
    );

    cvt_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stk_clr),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (stk_din),
        .top   (stk_top),
        .full  (stk_full)
    );

    cvt_outbuf u_outbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ob_load),
        .ld_kind   (ob_kind),
        .ld_val    (ob_val),
        .free      (ob_free),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_kind  (out_kind),
        .out_val   (out_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin : p_state
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin : p_next
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) state_d = (in_kind == K_START) ? ST_RUN : ST_FAIL;
            end
            ST_RUN: begin
                if (in_valid) begin
                    if ((act == ACT_PUSH) && stk_full) state_d = ST_FAIL;
                    else if (act == ACT_DONE)          state_d = ST_DONE;
                    else if (act == ACT_FAIL)          state_d = ST_FAIL;
                end
            end
            ST_DONE, ST_FAIL: begin
                if (in_valid && (in_kind == K_START)) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath controls
    always_comb begin : p_ctrl
        in_ready = 1'b0;
        stk_clr  = 1'b0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        stk_din  = K_START;
        ob_load  = 1'b0;
        ob_kind  = in_kind;
        ob_val   = in_val;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                stk_push = in_valid && (in_kind == K_START);
            end
            ST_RUN: begin
                unique case (act)
                    ACT_PUSH: begin
                        in_ready = 1'b1;
                        stk_push = in_valid && !stk_full;
                        stk_din  = in_kind;
                    end
                    ACT_POP: begin
                        if (ob_free) begin
                            stk_pop = in_valid;
                            ob_load = in_valid;
                            ob_kind = stk_top;
                            ob_val  = '0;
                        end
                    end
                    ACT_DROP: begin
                        in_ready = 1'b1;
                        stk_pop  = in_valid;
                    end
                    ACT_EMIT: begin
                        if (ob_free) begin
                            in_ready = 1'b1;
                            ob_load  = in_valid;
                            ob_val   = in_val;
                        end
                    end
                    ACT_DONE, ACT_FAIL: in_ready = 1'b1;
                    default: in_ready = 1'b0;
                endcase
            end
            ST_DONE, ST_FAIL: begin
                in_ready = 1'b1;
                if (in_valid && (in_kind == K_START)) begin
                    stk_clr  = 1'b1;
                    stk_push = 1'b1;
                end
            end
            default: in_ready = 1'b0;
        endcase
    end

    assign done  = (state_q == ST_DONE);
    assign error = (state_q == ST_FAIL);

endmodule

// File: rtl/cvt_checker.sv
module cvt_checker
    import cvt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [KIND_W-1:0] in_kind,
    input logic              out_valid,
    input logic              out_ready,
    input logic [KIND_W-1:0] out_kind,
    input logic [VAL_W-1:0]  out_val,
    input logic              done,
    input logic              error
);

    logic start_taken;
    assign start_taken = in_valid && in_ready && (in_kind == K_START);

    // R9: held output token does not change
    a_r9_hold_token: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_val));

    // R5: only operands and arithmetic operators leave the block
    a_r5_no_paren_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_kind <= K_DIV);

    // R12: status flags exclusive
    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R6: done persists until a start token is taken
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start_taken |=> done);

    // R12: error persists until a start token is taken
    a_r12_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start_taken |=> error);

    // R2: start after completion or failure clears the status
    a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) && start_taken |=> !done && !error);

endmodule

bind infix_postfix_cvt cvt_checker u_chk (.*);

// File: tb/sim_infix_postfix_cvt.sv
module sim_infix_postfix_cvt;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] in_kind = 4'd0;
    logic [7:0] in_val = 8'd0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [3:0] out_kind;
    logic [7:0] out_val;
    logic       done;
    logic       error;

    infix_postfix_cvt #(.STACK_DEPTH(DEPTH)) u0 (
        .clk, .rst_n, .in_valid, .in_ready, .in_kind, .in_val,
        .out_valid, .out_ready, .out_kind, .out_val, .done, .error
    );

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int sink_mode = 0;   // 0 always ready, 1 random, 2 stalled

    int tk_kind [0:255];
    int tk_val  [0:255];
    int tk_n;
    int ex_kind [0:255];
    int ex_val  [0:255];
    int ex_n;
    int ex_st;           // 1 done, 2 error
    int rx_kind [0:255];
    int rx_val  [0:255];
    int rx_n = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // output sink
    initial begin
        forever begin
            @(negedge clk);
            case (sink_mode)
                0: out_ready = 1'b1;
                1: out_ready = ($urandom % 4) != 0;
                default: out_ready = 1'b0;
            endcase
            #2;
            if (out_valid && out_ready && rx_n < 256) begin
                rx_kind[rx_n] = out_kind;
                rx_val[rx_n]  = out_val;
                rx_n++;
            end
        end
    end

    function automatic int rank(int k);
        return (k == 3 || k == 4) ? 2 : 1;
    endfunction

    function automatic bit arith(int k);
        return k >= 1 && k <= 4;
    endfunction

    // reference: precedence climbing over a software stack
    task automatic model();
        int stk [0:31];
        int sp = 0;
        ex_n = 0;
        ex_st = 0;
        for (int i = 0; i < tk_n && ex_st == 0; i++) begin
            int k = tk_kind[i];
            if (i == 0) begin
                if (k == 7) begin stk[0] = 7; sp = 1; end
                else ex_st = 2;
            end else if (k == 0) begin
                ex_kind[ex_n] = 0; ex_val[ex_n] = tk_val[i]; ex_n++;
            end else if (arith(k)) begin
                while (sp > 0 && arith(stk[sp-1]) && rank(stk[sp-1]) >= rank(k)) begin
                    ex_kind[ex_n] = stk[sp-1]; ex_val[ex_n] = 0; ex_n++; sp--;
                end
                if (sp == DEPTH) ex_st = 2;
                else begin stk[sp] = k; sp++; end
            end else if (k == 5) begin
                if (sp == DEPTH) ex_st = 2;
                else begin stk[sp] = k; sp++; end
            end else if (k == 6 || k == 8) begin
                while (sp > 0 && arith(stk[sp-1])) begin
                    ex_kind[ex_n] = stk[sp-1]; ex_val[ex_n] = 0; ex_n++; sp--;
                end
                if (k == 6 && stk[sp-1] == 5) sp--;
                else if (k == 8 && stk[sp-1] == 7) ex_st = 1;
                else ex_st = 2;
            end else begin
                ex_st = 2;
            end
        end
    endtask

    task automatic add_tok(int k, int v);
        tk_kind[tk_n] = k;
        tk_val[tk_n]  = v;
        tk_n++;
    endtask

    task automatic send(int k, int v, bit probe);
        @(negedge clk);
        in_valid = 1'b1;
        in_kind  = 4'(k);
        in_val   = 8'(v);
        #1;
        if (probe) begin
            logic [3:0] hk;
            logic [7:0] hv;
            check(!in_ready, "R10", "in_ready while a pop is pending", int'(in_ready), 0);
            hk = out_kind;
            hv = out_val;
            repeat (3) @(negedge clk);
            #1;
            check(!in_ready, "R10", "in_ready after stalled cycles", int'(in_ready), 0);
            check(out_valid && out_kind == hk && out_val == hv, "R9",
                  "held token kind", int'(out_kind), int'(hk));
            sink_mode = 1;
        end
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic run_case(string tag, int hold_idx);
        int st_act;
        bit ok;
        int bad;
        sink_mode = 0;
        repeat (4) @(negedge clk);
        rx_n = 0;
        model();
        sink_mode = 1;
        for (int i = 0; i < tk_n; i++) begin
            if (i == hold_idx - 1) begin
                sink_mode = 0;
                repeat (4) @(negedge clk);
                sink_mode = 2;
            end
            send(tk_kind[i], tk_val[i], i == hold_idx);
        end
        repeat (2) @(negedge clk);
        #1;
        st_act = done ? 1 : (error ? 2 : 0);
        check(st_act == ex_st, tag, "final status", st_act, ex_st);
        check(!(done && error), "R12", "flags exclusive", int'(done && error), 0);
        sink_mode = 0;
        repeat (5) @(negedge clk);
        ok = (rx_n == ex_n);
        bad = -1;
        for (int i = 0; i < ex_n && ok; i++) begin
            if (rx_kind[i] != ex_kind[i] || rx_val[i] != ex_val[i]) begin
                ok = 0;
                bad = i;
            end
        end
        if (!ok && bad >= 0)
            check(0, tag, $sformatf("token %0d kind*256+val", bad),
                  rx_kind[bad] * 256 + rx_val[bad], ex_kind[bad] * 256 + ex_val[bad]);
        else
            check(ok, tag, "output token count", rx_n, ex_n);
    endtask

    task automatic gen_rand();
        int open = 0;
        int need = 1;
        int steps = 4 + int'($urandom % 16);
        tk_n = 0;
        add_tok(7, 0);
        for (int s = 0; s < steps; s++) begin
            if (need != 0) begin
                if (open < 4 && ($urandom % 3) == 0) begin
                    add_tok(5, int'($urandom % 256)); open++;
                end else begin
                    add_tok(0, int'($urandom % 256)); need = 0;
                end
            end else if (open > 0 && ($urandom % 3) == 0) begin
                add_tok(6, 0); open--;
            end else begin
                add_tok(1 + int'($urandom % 4), int'($urandom % 256)); need = 1;
            end
        end
        if (need != 0) add_tok(0, int'($urandom % 256));
        while (open > 0) begin add_tok(6, 0); open--; end
        add_tok(8, 0);
        if (($urandom % 6) == 0) begin
            int idx = 1 + int'($urandom % (tk_n - 2));
            int r = int'($urandom % 10);
            tk_kind[idx] = (r == 9) ? 12 : r;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
        check(!done && !error, "R1", "status after reset", int'({done, error}), 0);
        check(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

        // R2: first token is not a start token
        tk_n = 0; add_tok(0, 5);
        run_case("R2", -1);
        // R2 restart, R6 empty expression
        tk_n = 0; add_tok(7, 0); add_tok(8, 0);
        run_case("R6", -1);

        // R4 R5: (8+2*5)/(1+3*2-4)
        tk_n = 0; add_tok(7, 0);
        add_tok(5, 0); add_tok(0, 8); add_tok(1, 9); add_tok(0, 2); add_tok(3, 9); add_tok(0, 5); add_tok(6, 0);
        add_tok(4, 0);
        add_tok(5, 0); add_tok(0, 1); add_tok(1, 0); add_tok(0, 3); add_tok(3, 0); add_tok(0, 2);
        add_tok(2, 0); add_tok(0, 4); add_tok(6, 0); add_tok(8, 0);
        run_case("R4", -1);

        // R4 left grouping: a - b - c / d / e
        tk_n = 0; add_tok(7, 0);
        add_tok(0, 10); add_tok(2, 0); add_tok(0, 11); add_tok(2, 0); add_tok(0, 12);
        add_tok(4, 0); add_tok(0, 13); add_tok(4, 0); add_tok(0, 14); add_tok(8, 0);
        run_case("R4", -1);

        // R3: operand values pass unchanged, including extremes
        tk_n = 0; add_tok(7, 0); add_tok(0, 255); add_tok(3, 0); add_tok(0, 0); add_tok(8, 0);
        run_case("R3", -1);

        // R7: stray close parenthesis, then trailing tokens ignored (R12)
        tk_n = 0; add_tok(7, 0); add_tok(0, 1); add_tok(6, 0); add_tok(0, 2); add_tok(1, 0); add_tok(0, 3); add_tok(8, 0);
        run_case("R7", -1);
        // R7: open parenthesis left pending at end
        tk_n = 0; add_tok(7, 0); add_tok(5, 0); add_tok(0, 1); add_tok(8, 0);
        run_case("R7", -1);

        // R8: fifteen open parens fill the stack exactly and still succeed
        tk_n = 0; add_tok(7, 0);
        for (int i = 0; i < 15; i++) add_tok(5, 0);
        add_tok(0, 77);
        for (int i = 0; i < 15; i++) add_tok(6, 0);
        add_tok(8, 0);
        run_case("R8", -1);
        // R8: sixteenth open paren overflows
        tk_n = 0; add_tok(7, 0);
        for (int i = 0; i < 16; i++) add_tok(5, 0);
        add_tok(0, 1); add_tok(8, 0);
        run_case("R8", -1);

        // R11: reserved kind and mid-stream start
        tk_n = 0; add_tok(7, 0); add_tok(0, 1); add_tok(12, 0); add_tok(8, 0);
        run_case("R11", -1);
        tk_n = 0; add_tok(7, 0); add_tok(0, 1); add_tok(1, 0); add_tok(7, 0);
        run_case("R11", -1);

        // R9 R10: stall while a pop is pending
        tk_n = 0; add_tok(7, 0); add_tok(0, 1); add_tok(3, 0); add_tok(0, 2);
        add_tok(1, 0); add_tok(0, 3); add_tok(8, 0);
        run_case("R9", 4);

        // random expressions under backpressure
        for (int c = 0; c < 80; c++) begin
            gen_rand();
            run_case("R3 R4 R5 R6", -1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule